// File: doc/BRIEF.md
# Reload Timer with Set/Clear Compare Output

The block is an up-counting timer with a reload register and one compare channel that drives a single output pin. On each cycle where the prescaled tick input is high and the run bit is set, the counter advances by one. When it would step past its all-ones value, it does not pass through zero. It loads the reload register instead, and the overflow clears the output pin. A counting step that lands the counter on the compare value drives the output pin high.

An overflow whose reload value equals the compare value leaves the pin unchanged. The set-on-match only applies to ordinary increments. So if software loads the timer, the reload and the compare registers with one value and then starts the timer, the pin never rises. Software reaches the block through four write ports: timer, reload, compare and control. The control word holds a run bit and an output-enable bit. The timer value is visible at an output port.

Top module: `rtc_cmp_timer`

## Requirements
- R1: While rst_ni is low, the counter, reload, compare and control registers clear to zero and out_o is low.
- R2: The counter rises by one at each clock edge where tick_i is high, control bit 0 (run) is set and tmr_we_i is low. In every other cycle without a write, the counter holds.
- R3: A counting step taken with the counter at all-ones loads the counter with the reload register value held at the start of that cycle. The counter does not pass through zero.
- R4: With control bit 1 (output enable) set, a counting increment that brings the counter to the compare value sets out_o high at that same clock edge.
- R5: With output enable set, an overflow step clears out_o if the held reload value differs from the compare value.
- R6: An overflow step whose held reload value equals the compare value leaves out_o unchanged. A high output stays high and a low output stays low.
- R7: If the timer, reload and compare registers all hold one value when counting starts, out_o stays low through repeated overflows.
- R8: A write to the timer register has priority over counting and reload in that cycle. The written value is not treated as a match.
- R9: With output enable clear, out_o holds its value through matches and overflows.
- R10: A compare write is used for the step taken in the same cycle, and for every later step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Prescaled count enable |
| tmr_we_i | input | 1 | Timer register write strobe |
| tmr_wdata_i | input | 16 | Timer write value |
| rld_we_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | 16 | Reload write value |
| cmp_we_i | input | 1 | Compare register write strobe |
| cmp_wdata_i | input | 16 | Compare write value |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 2 | Control write value: bit 0 run, bit 1 output enable |
| tmr_o | output | 16 | Current counter value |
| out_o | output | 1 | Compare output pin |

## Verification
The bench targets the overflow cycle in three variants:
- Reload differs from compare. A design that never clears the pin would leave it high.
- Reload equals compare. A design that treats the reload as a match would leave the pin high.
- All three registers equal. A design that treats the reload as a match would raise a pin that must stay low.

It also writes the timer to the compare value while a tick is present. A design that lets counting win over the write, or that flags the written value as a match, would show the wrong count or a raised pin. A compare write made in the same cycle as a step must be used at once; a design that waits for the register would miss the match. The bench also covers a disabled channel across a match and an overflow, where a design that ignores the enable would move the pin.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned CTL_W = 2;

  typedef struct packed {
    logic oe;   // bit 1: output enable
    logic run;  // bit 0: counting enabled
  } rtc_ctl_t;
endpackage

// File: rtl/rtc_regs.sv
module rtc_regs
  import rtc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rld_we_i,
  input  logic [W-1:0]     rld_wdata_i,
  input  logic             cmp_we_i,
  input  logic [W-1:0]     cmp_wdata_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic             run_o,
  output logic             oe_o,
  output logic [W-1:0]     rld_o,
  output logic [W-1:0]     cmp_eff_o
);
  rtc_ctl_t   ctl_q;
  logic [W-1:0] rld_q, cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      rld_q <= '0;
      cmp_q <= '0;
    end else begin
      if (ctl_we_i) ctl_q <= rtc_ctl_t'(ctl_wdata_i);
      if (rld_we_i) rld_q <= rld_wdata_i;
      if (cmp_we_i) cmp_q <= cmp_wdata_i;
    end
  end

  assign run_o     = ctl_q.run;
  assign oe_o      = ctl_q.oe;
  assign rld_o     = rld_q;
  // new compare value is seen by the step in its own write cycle
  assign cmp_eff_o = cmp_we_i ? cmp_wdata_i : cmp_q;

  // R10
  cmp_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_i |=> cmp_q == $past(cmp_wdata_i));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         run_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] rld_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] nxt_o,
  output logic         step_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q, cnt_d;
  logic         step, wrap;

  always_comb begin
    step = run_i & tick_i & ~wr_en_i;
    wrap = step & (cnt_q == CNT_MAX);
    if (wr_en_i)   cnt_d = wr_data_i;
    else if (wrap) cnt_d = rld_i;
    else if (step) cnt_d = cnt_q + 1'b1;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign nxt_o  = cnt_d;
  assign step_o = step;
  assign wrap_o = wrap;

  // R3
  wrap_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> cnt_q == $past(rld_i));
  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> $stable(cnt_q));
  // R8
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> cnt_q == $past(wr_data_i));
endmodule

// File: rtl/rtc_out_stage.sv
module rtc_out_stage #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         oe_i,
  input  logic         step_i,
  input  logic         wrap_i,
  input  logic [W-1:0] nxt_i,
  input  logic [W-1:0] cmp_i,
  input  logic [W-1:0] rld_i,
  output logic         out_o
);
  logic out_q, hit, clr;

  // a reload never counts as a match
  assign hit = step_i & ~wrap_i & (nxt_i == cmp_i);
  assign clr = wrap_i & (rld_i != cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          out_q <= 1'b0;
    else if (oe_i) begin
      if (hit)            out_q <= 1'b1;
      else if (clr)       out_q <= 1'b0;
    end
  end

  assign out_o = out_q;

  // R4
  set_on_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && step_i && !wrap_i && nxt_i == cmp_i) |=> out_q);
  // R5
  clr_on_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && wrap_i && rld_i != cmp_i) |=> !out_q);
  // R6
  eq_wrap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_i && rld_i == cmp_i) |=> $stable(out_q));
  // R9
  dis_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> $stable(out_q));
endmodule

// File: rtl/rtc_cmp_timer.sv
module rtc_cmp_timer
  import rtc_pkg::*;
#(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tmr_we_i,
  input  logic [TMR_W-1:0] tmr_wdata_i,
  input  logic             rld_we_i,
  input  logic [TMR_W-1:0] rld_wdata_i,
  input  logic             cmp_we_i,
  input  logic [TMR_W-1:0] cmp_wdata_i,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             out_o
);
  logic             run, oe, step, wrap;
  logic [TMR_W-1:0] rld, cmp_eff, nxt;

  rtc_regs #(.W(TMR_W)) u_regs (
    .clk_i, .rst_ni,
    .rld_we_i, .rld_wdata_i,
    .cmp_we_i, .cmp_wdata_i,
    .ctl_we_i, .ctl_wdata_i,
    .run_o(run), .oe_o(oe), .rld_o(rld), .cmp_eff_o(cmp_eff)
  );

  rtc_counter #(.W(TMR_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .run_i(run), .wr_en_i(tmr_we_i), .wr_data_i(tmr_wdata_i), .rld_i(rld),
    .cnt_o(tmr_o), .nxt_o(nxt), .step_o(step), .wrap_o(wrap)
  );

  rtc_out_stage #(.W(TMR_W)) u_out (
    .clk_i, .rst_ni,
    .oe_i(oe), .step_i(step), .wrap_i(wrap),
    .nxt_i(nxt), .cmp_i(cmp_eff), .rld_i(rld),
    .out_o
  );

  // R1
  rst_low_chk: assert property (@(posedge clk_i) !rst_ni |-> !out_o && tmr_o == '0);
endmodule

// File: tb/rtc_cmp_timer_tb_top.sv
module rtc_cmp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick = 1'b0, tmr_we = 1'b0, rld_we = 1'b0, cmp_we = 1'b0, ctl_we = 1'b0;
  logic [15:0] tmr_d = '0, rld_d = '0, cmp_d = '0;
  logic [1:0]  ctl_d = '0;
  logic [15:0] tmr_o;
  logic        out_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  rtc_cmp_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick),
    .tmr_we_i(tmr_we), .tmr_wdata_i(tmr_d),
    .rld_we_i(rld_we), .rld_wdata_i(rld_d),
    .cmp_we_i(cmp_we), .cmp_wdata_i(cmp_d),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_d),
    .tmr_o(tmr_o), .out_o(out_o)
  );

  typedef struct {
    logic [15:0] cnt;
    logic        out;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state, built from the requirements
  logic [15:0] m_cnt = '0, m_rld = '0, m_cmp = '0;
  logic [1:0]  m_ctl = '0;
  logic        m_out = 1'b0;

  task automatic drv(input logic tk,
                     input logic twe, input logic [15:0] tv,
                     input logic rwe, input logic [15:0] rv,
                     input logic cwe, input logic [15:0] cv,
                     input logic kwe, input logic [1:0] kv,
                     input string tag);
    logic [15:0] ce, nx;
    logic st, ov;
    exp_t e;
    @(negedge clk);
    tick = tk; tmr_we = twe; tmr_d = tv; rld_we = rwe; rld_d = rv;
    cmp_we = cwe; cmp_d = cv; ctl_we = kwe; ctl_d = kv;
    ce = cwe ? cv : m_cmp;
    st = m_ctl[0] & tk & ~twe;
    ov = st & (m_cnt == 16'hFFFF);
    nx = twe ? tv : ov ? m_rld : st ? m_cnt + 16'd1 : m_cnt;
    if (m_ctl[1]) begin
      if (st && !ov && nx == ce) m_out = 1'b1;
      else if (ov && m_rld != ce) m_out = 1'b0;
    end
    m_cnt = nx;
    if (rwe) m_rld = rv;
    if (cwe) m_cmp = cv;
    if (kwe) m_ctl = kv;
    e.cnt = m_cnt; e.out = m_out; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic tk(input logic t, input string tag);
    drv(t, 0, '0, 0, '0, 0, '0, 0, '0, tag);
  endtask

  // monitor: compares one expected item per clock, after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (tmr_o !== e.cnt || out_o !== e.out) begin
          fails++;
          $display("FAIL %s: tmr=%h out=%b expected tmr=%h out=%b",
                   e.tag, tmr_o, out_o, e.cnt, e.out);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (tmr_o !== 16'h0 || out_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: tmr=%h out=%b expected tmr=0000 out=0", tmr_o, out_o);
    end
    rst_ni = 1'b1;

    // R2 R4: start counting with a gapped tick pattern
    drv(1, 0, '0, 1, 16'h1000, 1, 16'h0005, 1, 2'b11, "R2 setup");
    tk(1, "R2"); tk(0, "R2"); tk(1, "R2"); tk(1, "R2");
    tk(0, "R2"); tk(1, "R2"); tk(1, "R4");
    tk(1, "R4 after");
    // R3 R5: overflow to reload, output cleared
    drv(1, 1, 16'hFFFD, 0, '0, 0, '0, 0, '0, "R8 write");
    tk(1, "R3"); tk(1, "R3"); tk(1, "R3 R5");
    // R6: reload equals compare, high output kept
    drv(0, 1, 16'h1FFF, 1, 16'h2000, 1, 16'h2000, 0, '0, "R6 setup");
    tk(1, "R4 R6");
    drv(0, 1, 16'hFFFF, 0, '0, 0, '0, 0, '0, "R6 write");
    tk(1, "R6");
    // clear again with differing reload
    drv(0, 1, 16'hFFFF, 1, 16'h0010, 1, 16'h2001, 0, '0, "R5 setup");
    tk(1, "R5");
    // R7: all equal, output stays low through overflows
    drv(0, 1, 16'hFFFE, 1, 16'hFFFE, 1, 16'hFFFE, 1, 2'b00, "R7 setup");
    drv(0, 0, '0, 0, '0, 0, '0, 1, 2'b11, "R7 start");
    for (int i = 0; i < 6; i++) tk(1, "R7");
    // R8: write to compare value with tick present
    drv(1, 1, 16'h4000, 0, '0, 1, 16'h4000, 0, '0, "R8");
    tk(1, "R8");
    // R9: set, disable, overflow must not move output
    drv(0, 0, '0, 0, '0, 1, 16'h4002, 0, '0, "R9 setup");
    tk(1, "R4");
    drv(0, 0, '0, 0, '0, 0, '0, 1, 2'b01, "R9 disable");
    drv(0, 1, 16'hFFFF, 0, '0, 0, '0, 0, '0, "R9 write");
    tk(1, "R9");
    // R10: compare written in the same cycle as the step
    drv(0, 1, 16'hFFFF, 1, 16'h0000, 1, 16'h0050, 1, 2'b11, "R10 setup");
    tk(1, "R5 R10");
    drv(1, 0, '0, 0, '0, 1, 16'h0001, 0, '0, "R10");
    // R2: run bit off holds the counter
    drv(0, 0, '0, 0, '0, 0, '0, 1, 2'b10, "R2 stop");
    tk(1, "R2 hold"); tk(1, "R2 hold");
    tk(0, "drain");

    @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule